// File: doc/BRIEF.md
# Sequential Booth Multiplier (Radix-2, Signed)

This block multiplies two signed two's-complement operands over several clock cycles. It uses radix-2 Booth recoding. A pulse on `start` while the block is idle captures the multiplicand and the multiplier. The block then runs exactly one iteration per operand bit. In each iteration it looks at the low multiplier bit together with a one-bit history flag. From that pair it adds the multiplicand to the upper half of the running product, subtracts it, or leaves it unchanged. It then shifts the whole {upper half, multiplier, history} chain one place to the right, arithmetically.

When the last iteration finishes, `done` is high for one cycle and `product` holds the full-width signed result. The result and the arithmetic-operation count stay on the ports until the next accepted start. `op_count` reports how many add or subtract steps the recoding chose. This makes the recoding decisions visible at the ports.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is asserted, and just after it is released, `busy`, `done`, `product` and `op_count` are all 0.
- R2: Suppose `start` is high on a clock edge while the block is idle. Then `busy` is high from that edge on, and `done` goes high exactly OPW edges later (8 for the default width). At that same edge `busy` drops.
- R3: When `done` is high, `product` equals the signed product of the captured operands as a 2·OPW-bit two's-complement value. This holds for every operand pair, including the most negative value in either position.
- R4: Each iteration decodes the pair {multiplier LSB, history bit}. The pair 01 adds the multiplicand, 10 subtracts it, and 00 or 11 does no arithmetic. The history bit starts at 0. Each shift moves the old LSB into the history bit. As a result, `op_count` at `done` equals the number of positions i (0..OPW-1) where multiplier bit i differs from bit i-1, with bit -1 taken as 0.
- R5: Multiplicand 77 and multiplier -25 produce product 16'hF87B (-1925) with `op_count` equal to 3.
- R6: `start` has no effect while `busy` or `done` is high. The completion time, `product` and `op_count` are those of the operands captured at the accepted start.
- R7: After `done` falls, `product` and `op_count` keep their values until the next accepted start.
- R8: An accepted start clears `op_count` to 0 on the same edge.
- R9: `done` is never high on two consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication (accepted only when idle) |
| mcand | input | OPW | Multiplicand, signed |
| mplier | input | OPW | Multiplier, signed |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion strobe |
| product | output | 2*OPW | Signed product |
| op_count | output | CNTW | Number of add/subtract steps of the last run |

## Verification
The hardest situation to reach is a restart request that arrives while a run is in progress or during the completion cycle itself. Here a wrong design would quietly reload its operands or stretch the strobe. The bench can hold `start` high with fresh random operands through every iteration and through the `done` cycle. It then checks that timing, product and count still belong to the first operands. The most negative multiplicand makes a subtraction overflow an operand-wide accumulator. Directed runs with -128 in either position, and an alternating-bit multiplier that forces an arithmetic step in every iteration, drive the adder through these cases.

// File: rtl/booth_pkg.sv
package booth_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } booth_state_e;

   typedef enum logic [1:0] {
      OP_SKIP = 2'd0,
      OP_ADD  = 2'd1,
      OP_SUB  = 2'd2
   } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_pkg::*;
(
   input  logic      lsb,
   input  logic      prev,
   output booth_op_e op
);
   always_comb begin
      unique case ({lsb, prev})
         2'b01:   op = OP_ADD;
         2'b10:   op = OP_SUB;
         default: op = OP_SKIP;
      endcase
   end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
   parameter int W      = 9,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum
);
   logic [W-1:0] b_eff;

   assign b_eff = b ^ {W{sub}};

   generate
      if (RIPPLE) begin : g_ripple
         logic [W-1:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i] = a[i] ^ b_eff[i] ^ cy[i];
            if (i < W-1) begin : g_carry
               assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
            end
         end
      end else begin : g_behav
         assign sum = a + b_eff + {{(W-1){1'b0}}, sub};
      end
   endgenerate
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
   import booth_pkg::*;
#(
   parameter int OPW = 8,
   localparam int ITW = (OPW > 2) ? $clog2(OPW) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   booth_state_e state_q, state_d;
   logic [ITW-1:0] iter_q, iter_d;
   logic last_iter;

   assign last_iter = (iter_q == ITW'(OPW-1));
   assign load = (state_q == ST_IDLE) && start;
   assign step = (state_q == ST_RUN);
   assign busy = (state_q == ST_RUN);
   assign done = (state_q == ST_DONE);

   always_comb begin
      state_d = state_q;
      iter_d  = iter_q;
      unique case (state_q)
         ST_IDLE: if (start) begin
            state_d = ST_RUN;
            iter_d  = '0;
         end
         ST_RUN: begin
            if (last_iter) state_d = ST_DONE;
            else           iter_d  = iter_q + 1'b1;
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         iter_q  <= '0;
      end else begin
         state_q <= state_d;
         iter_q  <= iter_d;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);   // R9
   AST_RUN_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));   // R2
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> !busy);   // R6
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
   import booth_pkg::*;
#(
   parameter int OPW    = 8,
   parameter bit RIPPLE = 1'b1,
   parameter int CNTW   = $clog2(OPW + 1),
   localparam int AW    = OPW + 1,
   localparam int PW    = 2 * OPW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [OPW-1:0]  mcand,
   input  logic [OPW-1:0]  mplier,
   output logic            busy,
   output logic            done,
   output logic [PW-1:0]   product,
   output logic [CNTW-1:0] op_count
);
   generate
      if (OPW < 2) begin : g_bad_opw
         initial $fatal(1, "booth_seq_mult: OPW must be at least 2");
      end
      if ((1 << CNTW) <= OPW) begin : g_bad_cntw
         initial $fatal(1, "booth_seq_mult: CNTW too narrow for OPW");
      end
   endgenerate

   logic           load, step;
   logic [AW-1:0]  acc_q, m_q, sum_raw, sum_sel;
   logic [OPW-1:0] q_q;
   logic           prev_q;
   logic [CNTW-1:0] cnt_q;
   booth_op_e      op;

   booth_ctrl #(.OPW(OPW)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   booth_recode u_rec (
      .lsb  (q_q[0]),
      .prev (prev_q),
      .op   (op)
   );

   booth_addsub #(.W(AW), .RIPPLE(RIPPLE)) u_add (
      .a   (acc_q),
      .b   (m_q),
      .sub (op == OP_SUB),
      .sum (sum_raw)
   );

   assign sum_sel = (op == OP_SKIP) ? acc_q : sum_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         m_q    <= '0;
         q_q    <= '0;
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else if (load) begin
         acc_q  <= '0;
         m_q    <= {mcand[OPW-1], mcand};
         q_q    <= mplier;
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else if (step) begin
         acc_q  <= {sum_sel[AW-1], sum_sel[AW-1:1]};
         q_q    <= {sum_sel[0], q_q[OPW-1:1]};
         prev_q <= q_q[0];
         if (op != OP_SKIP) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign product  = {acc_q[OPW-1:0], q_q};
   assign op_count = cnt_q;

   AST_PREV_FOLLOWS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (prev_q == $past(q_q[0])));   // R4
   AST_OPCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      op_count <= CNTW'(OPW));   // R4
   AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(m_q));   // R6
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load) |=> ($stable(product) && $stable(op_count)));   // R7
   AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (op_count == '0));   // R8
endmodule

// File: tb/booth_seq_mult_tb.sv
module booth_seq_mult_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  mcand = '0;
   logic [7:0]  mplier = '0;
   logic        busy, done;
   logic [15:0] product;
   logic [3:0]  op_count;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   booth_seq_mult dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mcand    (mcand),
      .mplier   (mplier),
      .busy     (busy),
      .done     (done),
      .product  (product),
      .op_count (op_count)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_prod(input logic [7:0] a, input logic [7:0] b);
      logic signed [15:0] sa, sb;
      sa = $signed({{8{a[7]}}, a});
      sb = $signed({{8{b[7]}}, b});
      return 16'(sa * sb);
   endfunction

   function automatic int exp_ops(input logic [7:0] x);
      int n = 0;
      logic prev = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (x[i] != prev) n++;
         prev = x[i];
      end
      return n;
   endfunction

   task automatic run_mul(input logic [7:0] a, input logic [7:0] b, input bit inj);
      int first = 0;
      logic [15:0] p_done = '0;
      logic [3:0]  c_done = '0;
      logic [15:0] ep = exp_prod(a, b);
      int eo = exp_ops(b);
      @(negedge clk);
      mcand = a; mplier = b; start = 1'b1;
      @(negedge clk);                       // start edge passed
      chk(busy == 1'b1, "R2", "busy after start", busy, 1);
      chk(op_count == 4'd0, "R8", "op_count cleared", op_count, 0);
      for (int k = 1; k <= 9; k++) begin
         if (inj) begin
            start = 1'b1; mcand = 8'($urandom); mplier = 8'($urandom);
         end else start = 1'b0;
         @(negedge clk);
         if (done && first == 0) begin
            first = k; p_done = product; c_done = op_count;
         end
         if (k == 9) chk(done == 1'b0, "R9", "done single cycle", done, 0);
      end
      start = 1'b0;
      chk(first == 8, inj ? "R6" : "R2", "done edge", first, 8);
      chk(p_done == ep, inj ? "R6" : "R3", "product", p_done, ep);
      chk(int'(c_done) == eo, inj ? "R6" : "R4", "op_count", c_done, eo);
      chk(busy == 1'b0, "R6", "idle after done", busy, 0);
      @(negedge clk);
      chk(product == p_done, "R7", "product hold", product, p_done);
      chk(op_count == c_done, "R7", "op_count hold", op_count, c_done);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      int seed_v;
      seed_v = $urandom(32'd20711);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(busy == 0 && done == 0, "R1", "status in reset", {busy, done}, 0);
      chk(product == 0 && op_count == 0, "R1", "outputs in reset", product, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(product == 0 && busy == 0, "R1", "after release", product, 0);

      // R5 directed example
      run_mul(8'd77, 8'(-25), 1'b0);
      chk(product == 16'hF87B, "R5", "77 x -25", product, 16'hF87B);
      chk(op_count == 4'd3, "R5", "77 x -25 ops", op_count, 3);

      // corner cases (R3, R4)
      run_mul(8'h80, 8'h80, 1'b0);
      run_mul(8'h80, 8'h7F, 1'b0);
      run_mul(8'h7F, 8'h80, 1'b0);
      run_mul(8'h00, 8'hA5, 1'b0);
      run_mul(8'hFF, 8'hFF, 1'b0);
      run_mul(8'h33, 8'h55, 1'b0);   // every pair arithmetic
      run_mul(8'h9C, 8'hAA, 1'b0);
      run_mul(8'h12, 8'h00, 1'b0);   // no arithmetic at all

      // start held through a run (R6)
      run_mul(8'd77, 8'(-25), 1'b1);
      run_mul(8'h80, 8'h55, 1'b1);

      for (int t = 0; t < 40; t++) begin
         run_mul(8'($urandom), 8'($urandom), ($urandom % 4) == 0);
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule